// File: doc/BRIEF.md
# Digital dual-mixer phase detector

This block measures the phase offset between a reference clock and a feedback clock that share a nominal frequency of 62.5 MHz, which gives a 16 ns cycle. It does not compare input edges directly. Instead, an offset clock runs slightly slower than the inputs, at f_in·2^N/(1+2^N), and samples each input in a flip-flop. Sampling this way turns each input into a slow beat signal. The beat frequency is proportional to the input frequency. The beat signals keep the phase relation of the inputs as a fraction of a cycle, but the time difference between them is stretched by a factor of 1+2^N. A plain counter can therefore resolve that difference.

All logic in the block runs on the offset clock. Each beat signal passes through a two-flop synchroniser and then a run-length deglitcher. A free-running counter stamps every accepted rising beat edge. When both channels have produced an edge, the block reports the feedback stamp minus the reference stamp minus a programmable setpoint. The result is wrapped into a signed value and comes with a single-cycle valid strobe. A loop filter downstream divides the result by 1+2^N to obtain the input time error. Generating the offset clock and controlling the oscillator are done outside this block.

Top module: `phase_beat_detector`

## Requirements
- R1: While reset is held low, and after it is released until the first pair of edges completes, `phaseErrValid` is 0 and `phaseErr` is 0.
- R2: For a completed pair, `phaseErr` equals (feedback rise cycle − reference rise cycle − `setpoint`) modulo 2^CNT_W. The rise cycles are counted in offset-clock cycles, and `setpoint` is read as a CNT_W-bit two's complement value.
- R3: `phaseErr` is a CNT_W-bit two's complement value. A feedback edge that comes before its reference edge gives a negative result. A distance of 2^(CNT_W−1) or more wraps into the negative range. The result is also correct when the free-running counter rolls over between the two stamps.
- R4: A high run of fewer than RUN_LEN consecutive samples on a beat input is not taken as an edge. After an accepted rise, the input must be low for at least RUN_LEN samples before another rise can be accepted.
- R5: `phaseErrValid` pulses for exactly one cycle, and only once both channels have supplied an edge since the last report. Edges on one channel alone never produce a report.
- R6: If a channel produces a second accepted edge before its partner arrives, the later stamp replaces the earlier one.
- R7: Edges accepted on both channels in the same cycle produce a report equal to −`setpoint`.
- R8: Suppose the input that completes a pair goes high just before offset-clock edge 0 and stays high. Then `phaseErrValid` is high during the cycle after edge RUN_LEN+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| offsetClk | input | 1 | Offset sampling clock; every register in the block runs on it |
| rstN | input | 1 | Active-low synchronous reset |
| refClkIn | input | 1 | Reference input clock, sampled by the offset clock |
| fbClkIn | input | 1 | Feedback input clock, sampled by the offset clock |
| setpoint | input | CNT_W | Desired feedback-minus-reference offset in counter units, two's complement |
| phaseErr | output | CNT_W | Signed, wrapped phase error of the last completed pair |
| phaseErrValid | output | 1 | One-cycle strobe marking a new `phaseErr` |

## Verification
Two cases are hard to reach from the ports. The first is a glitch on the feedback beat while a reference stamp is already pending, because an accepted glitch would show up only as an early report. The stimulus places a run one sample short of the acceptance length on the feedback input after a reference edge has been accepted. It then checks that no report appears and that the later real edge is the one measured. The second case is counter rollover and negative wrap. Randomly ordered pairs with gaps of up to several hundred cycles cover it, and one directed gap larger than half the counter range forces it.

// File: rtl/ddmtd_pkg.sv
package ddmtd_pkg;
  // Strobes from the pairing control to the stamp datapath
  typedef struct packed {
    logic takeRef;  // capture counter as reference stamp
    logic takeFb;   // capture counter as feedback stamp
    logic emit;     // publish error this cycle
  } dmtdStrobe_t;
endpackage

// File: rtl/beat_deglitch.sv
module beat_deglitch #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawBeat,
  output logic riseStb
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic [1:0]       syncQ;
  logic             level;
  logic [RUN_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      level   <= 1'b0;
      runCnt  <= '0;
      riseStb <= 1'b0;
    end else begin
      syncQ   <= {syncQ[0], rawBeat};
      riseStb <= 1'b0;
      if (syncQ[1] != level) begin
        if (runCnt == RUN_W'(RUN_LEN - 1)) begin
          level   <= syncQ[1];
          runCnt  <= '0;
          riseStb <= syncQ[1];
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        runCnt <= '0;
      end
    end
  end

  // R4: an accepted rise is a single-cycle event
  a_r4_single_rise: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |=> !riseStb);

  // R4: a rise is only accepted while the settled level was low
  a_r4_rise_from_low: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |-> level);
endmodule

// File: rtl/dmtd_control.sv
module dmtd_control
  import ddmtd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        refEdge,
  input  logic        fbEdge,
  output dmtdStrobe_t strobe
);
  logic seenRef, seenFb;
  logic refAvail, fbAvail;

  always_comb begin
    refAvail      = seenRef | refEdge;
    fbAvail       = seenFb | fbEdge;
    strobe.takeRef = refEdge;
    strobe.takeFb  = fbEdge;
    strobe.emit    = refAvail && fbAvail && (refEdge || fbEdge);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenRef <= 1'b0;
      seenFb  <= 1'b0;
    end else if (strobe.emit) begin
      seenRef <= 1'b0;
      seenFb  <= 1'b0;
    end else begin
      seenRef <= refAvail;
      seenFb  <= fbAvail;
    end
  end

  // R5: a report consumes both pending stamps
  a_r5_pair_consumed: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |=> !(seenRef && seenFb));
endmodule

// File: rtl/dmtd_datapath.sv
module dmtd_datapath
  import ddmtd_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  dmtdStrobe_t      strobe,
  input  logic [CNT_W-1:0] setpoint,
  output logic [CNT_W-1:0] errOut,
  output logic             errValid
);
  logic [CNT_W-1:0] freeCnt;
  logic [CNT_W-1:0] refStamp, fbStamp;
  logic [CNT_W-1:0] refSel, fbSel, errNext;

  always_comb begin
    refSel  = strobe.takeRef ? freeCnt : refStamp;
    fbSel   = strobe.takeFb  ? freeCnt : fbStamp;
    errNext = fbSel - refSel - setpoint;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeCnt  <= '0;
      refStamp <= '0;
      fbStamp  <= '0;
      errOut   <= '0;
      errValid <= 1'b0;
    end else begin
      freeCnt  <= freeCnt + 1'b1;
      refStamp <= refSel;
      fbStamp  <= fbSel;
      errValid <= strobe.emit;
      if (strobe.emit) errOut <= errNext;
    end
  end

  // R5: the valid strobe never lasts two cycles
  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    errValid |=> !errValid);

  // R2: the reported value only changes together with a valid strobe
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !errValid |-> $stable(errOut));
endmodule

// File: rtl/phase_beat_detector.sv
module phase_beat_detector
  import ddmtd_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int RUN_LEN = 4
) (
  input  logic             offsetClk,
  input  logic             rstN,
  input  logic             refClkIn,
  input  logic             fbClkIn,
  input  logic [CNT_W-1:0] setpoint,
  output logic [CNT_W-1:0] phaseErr,
  output logic             phaseErrValid
);
  localparam int CHANS = 2;

  logic [CHANS-1:0] rawBeats;
  logic [CHANS-1:0] beatRise;
  dmtdStrobe_t      strobe;

  assign rawBeats = {fbClkIn, refClkIn};

  for (genvar ch = 0; ch < CHANS; ch++) begin : g_beat
    beat_deglitch #(.RUN_LEN(RUN_LEN)) i_deglitch (
      .clk     (offsetClk),
      .rstN    (rstN),
      .rawBeat (rawBeats[ch]),
      .riseStb (beatRise[ch])
    );
  end

  dmtd_control i_control (
    .clk     (offsetClk),
    .rstN    (rstN),
    .refEdge (beatRise[0]),
    .fbEdge  (beatRise[1]),
    .strobe  (strobe)
  );

  dmtd_datapath #(.CNT_W(CNT_W)) i_datapath (
    .clk      (offsetClk),
    .rstN     (rstN),
    .strobe   (strobe),
    .setpoint (setpoint),
    .errOut   (phaseErr),
    .errValid (phaseErrValid)
  );

  // R5: every report is triggered by an accepted edge one cycle earlier
  a_r5_valid_after_edge: assert property (@(posedge offsetClk) disable iff (!rstN)
    phaseErrValid |-> $past(|beatRise));

  // R7: coincident edges report minus the setpoint
  a_r7_coincident: assert property (@(posedge offsetClk) disable iff (!rstN)
    (&beatRise) |=> (phaseErrValid && (CNT_W'(phaseErr + $past(setpoint)) == '0)));
endmodule

// File: tb/test_phase_beat_detector.sv
module test_phase_beat_detector;
  localparam int W = 10;
  localparam int M = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         refIn = 1'b0;
  logic         fbIn = 1'b0;
  logic [W-1:0] setpoint = '0;
  logic [W-1:0] phaseErr;
  logic         phaseErrValid;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int validCount = 0;
  logic [W-1:0] lastErr = '0;
  int refCyc = 0;
  int fbCyc = 0;

  always #2 clk = ~clk;

  phase_beat_detector #(.CNT_W(W), .RUN_LEN(M)) i_phase_beat_detector (
    .offsetClk     (clk),
    .rstN          (rstN),
    .refClkIn      (refIn),
    .fbClkIn       (fbIn),
    .setpoint      (setpoint),
    .phaseErr      (phaseErr),
    .phaseErrValid (phaseErrValid)
  );

  function automatic logic [W-1:0] expErr(int gap, logic [W-1:0] sp);
    return W'(gap) - sp;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (phaseErrValid) begin
      validCount++;
      lastErr = phaseErr;
    end
  endtask

  task automatic settle();
    refIn = 1'b0;
    fbIn  = 1'b0;
    repeat (M + 6) tick();
    validCount = 0;
  endtask

  // Wait for a report after the completing edge, check latency and one-cycle width
  task automatic awaitReport(int gap, logic [W-1:0] sp, string req);
    int lat = 0;
    logic [W-1:0] e;
    while (validCount == 0 && lat < M + 10) begin
      tick();
      lat++;
    end
    check(lat == M + 3, "R8 latency", lat, M + 3);
    e = expErr(gap, sp);
    check(lastErr == e, req, $signed(lastErr), $signed(e));
    tick();
    check(phaseErrValid == 1'b0 && validCount == 1, "R5 one-cycle valid",
          validCount, 1);
  endtask

  task automatic pairTest(bit fbFirst, int gap, logic [W-1:0] sp, string req);
    setpoint = sp;
    settle();
    if (fbFirst) begin fbIn = 1'b1; fbCyc = cyc; end
    else begin refIn = 1'b1; refCyc = cyc; end
    for (int i = 0; i < gap; i++) tick();
    check(validCount == 0, "R5 no report on single edge", validCount, 0);
    if (fbFirst) begin refIn = 1'b1; refCyc = cyc; end
    else begin fbIn = 1'b1; fbCyc = cyc; end
    awaitReport(fbCyc - refCyc, sp, req);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20161));
    repeat (3) tick();
    check(phaseErrValid == 1'b0, "R1 valid in reset", phaseErrValid, 0);
    check(phaseErr == '0, "R1 error in reset", phaseErr, 0);
    rstN = 1'b1;
    repeat (4) tick();
    check(phaseErrValid == 1'b0 && phaseErr == '0, "R1 after reset", phaseErr, 0);

    // Directed pairs
    pairTest(1'b0, 10, W'(0), "R2 ref first");
    pairTest(1'b1, 10, W'(5), "R3 fb first negative");
    pairTest(1'b0, 600, W'(0), "R3 wrap past half range");
    pairTest(1'b0, 0, W'(7), "R7 coincident edges");
    pairTest(1'b1, 0, W'(1000), "R7 coincident negative setpoint");

    // R4: short fb glitch while a reference stamp is pending
    setpoint = W'(3);
    settle();
    refIn = 1'b1; refCyc = cyc;
    repeat (M + 6) tick();
    fbIn = 1'b1;
    repeat (M - 1) tick();
    fbIn = 1'b0;
    repeat (M + 8) tick();
    check(validCount == 0, "R4 glitch ignored", validCount, 0);
    fbIn = 1'b1; fbCyc = cyc;
    awaitReport(fbCyc - refCyc, setpoint, "R4 real edge measured");

    // R6: repeated reference edge, the later stamp wins
    setpoint = W'(0);
    settle();
    refIn = 1'b1;
    repeat (M + 4) tick();
    refIn = 1'b0;
    repeat (M + 4) tick();
    refIn = 1'b1; refCyc = cyc;
    repeat (7) tick();
    check(validCount == 0, "R5 repeated ref alone", validCount, 0);
    fbIn = 1'b1; fbCyc = cyc;
    awaitReport(fbCyc - refCyc, setpoint, "R6 latest stamp kept");

    // Random pairs: order, gap and setpoint
    for (int k = 0; k < 24; k++) begin
      bit fbf;
      int g;
      logic [W-1:0] sp;
      fbf = 1'($urandom % 2);
      g   = int'($urandom % 700);
      sp  = W'($urandom);
      pairTest(fbf, g, sp, "R2 random pair");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule